// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers interrupt requests from five sources and hands the CPU one vector at a time. The sources are an external pin, a change on any enabled pin of a six-bit port, a timer overflow, a memory-ready event and a comparator event. Each source has a pending flag. A flag is gated by its own enable and by one global enable bit. When several sources are pending, the one with the lowest vector index is offered to the CPU.

The CPU side uses a request/index/acknowledge handshake. Acknowledging a vector clears the flag of the served source and drops the global enable. A return strobe sets the global enable again. After a return, a retire strobe from the CPU must show that one main-program instruction has completed before another vector can be requested.

Port pins pass through a synchronizer. Each synchronized sample is compared with the previous sample to find rising edges, falling edges and changes. The external pin can be sensed in one of four modes. A small register port gives read and write access to the flags, the enables, the control bits and the pin-change pin selection.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset the vector request is low and every register field reads zero. Zero in the control register means level sense with the global enable off. The pin sample history resets to all ones, matching idle-high pins.
- R2: Register map by `reg_addr_i`:
  - 0 holds the flags: bit0 external, bit1 pin change, bit2 timer, bit3 memory ready, bit4 comparator.
  - 1 holds the source enables, in the same bit order.
  - 2 holds the control bits: bit0 is the global enable, bits 2:1 are the external sense mode.
  - 3 holds the pin-change enables, one bit per port pin in bits 5:0.
  - `reg_rdata_o` follows `reg_addr_i` combinationally.
- R3: A source raises a request only when its pending state, its enable bit and the global enable are all set.
- R4: Among requesting sources, the lowest vector index wins. The indices are external 1, pin change 2, timer 3, memory ready 4, comparator 5.
- R5: Once `vec_req_o` rises, it stays high and `vec_idx_o` stays unchanged until a cycle with `vec_ack_i` high.
- R6: An acknowledge clears the flag of the served source and the global enable bit. A `reti_i` pulse sets the global enable bit.
- R7: A flag stays set while its enable or the global enable is off. Writing a one to a flag bit clears that flag. Writing a zero to a flag bit leaves it unchanged.
- R8: The external pin sense mode is 00 low level, 01 any change, 10 falling edge, 11 rising edge. In each edge mode, only the selected edge sets the external flag.
- R9: In low-level mode no external flag is latched and flag bit0 reads zero. The external source is pending for as long as the synchronized pin is low.
- R10: A change in either direction on any port pin whose pin-change enable is set sets the pin-change flag. A single edge on the external pin can set both the external flag and the pin-change flag.
- R11: Pins pass through a two-stage synchronizer before edge detection. Any pin pulse held for two clock cycles or longer is detected.
- R12: After a `reti_i` pulse, no vector is requested until a `retire_i` pulse reports one completed main-program instruction.
- R13: A one-cycle pulse on the timer, memory-ready or comparator input sets that source's flag. If a hardware set and a software clear hit the same flag in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 6 | Port pin levels, asynchronous |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| mem_rdy_i | input | 1 | Memory-ready pulse |
| cmp_evt_i | input | 1 | Comparator event pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| vec_req_o | output | 1 | Vector request to the CPU |
| vec_idx_o | output | 3 | Index of the requested vector |
| vec_ack_i | input | 1 | CPU has entered the vector |
| reti_i | input | 1 | Return-from-interrupt strobe |
| retire_i | input | 1 | One main-program instruction has completed |

## Verification
The bench builds the block with its defaults: a six-pin port, the external input on pin 2 and two synchronizer stages. The short synchronizer keeps each pin event only three cycles from its flag, so the two-cycle pulse boundary can be tested directly. Placing the external input on pin 2 also lets that pin be enabled for pin change, so the case where one edge sets two flags can be exercised. All three hardware event sources are pulsed together, and the bench then steps through the priority order by walking the acknowledge, return and retire sequence.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_SRC = 5;
    localparam int VEC_W   = 3;

    localparam int SRC_EXT = 0;
    localparam int SRC_PCH = 1;
    localparam int SRC_TMR = 2;
    localparam int SRC_MEM = 3;
    localparam int SRC_CMP = 4;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef enum logic [1:0] {
        REG_FLAG = 2'd0,
        REG_MASK = 2'd1,
        REG_CTRL = 2'd2,
        REG_PCEN = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irq_pin_sampler.sv
module irq_pin_sampler #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] sync;
        logic [W-1:0]             prev;
    } smp_st_t;

    smp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sync[0] = pin_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.sync[s] = st_q.sync[s-1];
        end
        st_d.prev = st_q.sync[LAST];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign level_o = st_q.sync[LAST];
    assign rise_o  = st_q.sync[LAST] & ~st_q.prev;
    assign fall_o  = ~st_q.sync[LAST] & st_q.prev;

    // An edge reported now must show up as the history value one cycle later
    p_edge_history_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o != '0) |=> ((st_q.prev & $past(rise_o)) == $past(rise_o)));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_pkg::*;
#(
    parameter int PORT_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_level_i,
    input  logic               ext_rise_i,
    input  logic               ext_fall_i,
    input  logic [PORT_W-1:0]  pin_chg_i,
    input  logic [2:0]         hw_evt_i,
    input  logic               reg_wr_i,
    input  logic [1:0]         reg_addr_i,
    input  logic [7:0]         reg_wdata_i,
    output logic [7:0]         reg_rdata_o,
    input  logic               take_i,
    input  logic [VEC_W-1:0]   take_src_i,
    input  logic               reti_i,
    output logic [NUM_SRC-1:0] active_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] flags;
        logic [NUM_SRC-1:0] mask;
        logic               gie;
        sense_e             sense;
        logic [PORT_W-1:0]  pcen;
    } bank_st_t;

    bank_st_t st_d, st_q;

    logic [NUM_SRC-1:0] set_v;
    logic [NUM_SRC-1:0] clr_v;
    logic [NUM_SRC-1:0] pend_v;
    logic               is_level;

    assign is_level = (st_q.sense == SENSE_LOW);

    always_comb begin
        st_d = st_q;

        set_v = '0;
        unique case (st_q.sense)
            SENSE_ANY:  set_v[SRC_EXT] = ext_rise_i | ext_fall_i;
            SENSE_FALL: set_v[SRC_EXT] = ext_fall_i;
            SENSE_RISE: set_v[SRC_EXT] = ext_rise_i;
            default:    set_v[SRC_EXT] = 1'b0;
        endcase
        set_v[SRC_PCH] = |(pin_chg_i & st_q.pcen);
        set_v[SRC_TMR] = hw_evt_i[0];
        set_v[SRC_MEM] = hw_evt_i[1];
        set_v[SRC_CMP] = hw_evt_i[2];

        clr_v = '0;
        if (reg_wr_i && reg_addr_i == REG_FLAG) clr_v = reg_wdata_i[NUM_SRC-1:0];
        if (take_i) clr_v[take_src_i] = 1'b1;

        st_d.flags = (st_q.flags & ~clr_v) | set_v;
        if (is_level) st_d.flags[SRC_EXT] = 1'b0;

        if (reg_wr_i) begin
            unique case (reg_addr_i)
                REG_MASK: st_d.mask = reg_wdata_i[NUM_SRC-1:0];
                REG_CTRL: begin
                    st_d.gie   = reg_wdata_i[0];
                    st_d.sense = sense_e'(reg_wdata_i[2:1]);
                end
                REG_PCEN: st_d.pcen = reg_wdata_i[PORT_W-1:0];
                default: ;
            endcase
        end
        if (take_i) st_d.gie = 1'b0;
        if (reti_i) st_d.gie = 1'b1;

        pend_v = st_q.flags;
        if (is_level) pend_v[SRC_EXT] = ~ext_level_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = pend_v & st_q.mask & {NUM_SRC{st_q.gie}};

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            REG_FLAG: begin
                reg_rdata_o[NUM_SRC-1:0] = st_q.flags;
                if (is_level) reg_rdata_o[SRC_EXT] = 1'b0;
            end
            REG_MASK: reg_rdata_o[NUM_SRC-1:0] = st_q.mask;
            REG_CTRL: reg_rdata_o[2:0] = {st_q.sense, st_q.gie};
            REG_PCEN: reg_rdata_o[PORT_W-1:0] = st_q.pcen;
            default: ;
        endcase
    end

    p_take_drops_gie_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && !reti_i |=> !st_q.gie);

    p_reti_sets_gie_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reti_i |=> st_q.gie);

    p_level_no_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        is_level && $past(is_level) |-> !st_q.flags[SRC_EXT]);

    p_hw_set_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
        hw_evt_i[0] |=> st_q.flags[SRC_TMR]);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] active_i,
    input  logic               vec_ack_i,
    input  logic               reti_i,
    input  logic               retire_i,
    output logic               vec_req_o,
    output logic [VEC_W-1:0]   vec_idx_o,
    output logic               take_o,
    output logic [VEC_W-1:0]   take_src_o
);
    typedef struct packed {
        logic             req;
        logic [VEC_W-1:0] idx;
        logic             block;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic [VEC_W-1:0] sel;
    logic             found;

    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (active_i[i]) begin
                sel   = VEC_W'(i);
                found = 1'b1;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (st_q.req) begin
            if (vec_ack_i) st_d.req = 1'b0;
        end else if (found && !st_q.block) begin
            st_d.req = 1'b1;
            st_d.idx = sel + VEC_W'(1);
        end
        if (reti_i)        st_d.block = 1'b1;
        else if (retire_i) st_d.block = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vec_req_o  = st_q.req;
    assign vec_idx_o  = st_q.idx;
    assign take_o     = st_q.req & vec_ack_i;
    assign take_src_o = st_q.idx - VEC_W'(1);

    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.req && !vec_ack_i |=> st_q.req && $stable(st_q.idx));

    p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.req |-> (st_q.idx >= VEC_W'(1)) && (st_q.idx <= VEC_W'(NUM_SRC)));

    p_req_needs_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.req) |-> $past(active_i != '0));

    p_holdoff_r12: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.block && !st_q.req |=> !st_q.req);
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
    import irq_pkg::*;
#(
    parameter int PORT_W      = 6,
    parameter int EXT_PIN     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pin_i,
    input  logic              tmr_ovf_i,
    input  logic              mem_rdy_i,
    input  logic              cmp_evt_i,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [7:0]        reg_wdata_i,
    output logic [7:0]        reg_rdata_o,
    output logic              vec_req_o,
    output logic [2:0]        vec_idx_o,
    input  logic              vec_ack_i,
    input  logic              reti_i,
    input  logic              retire_i
);
    logic [PORT_W-1:0]  lvl, rise, fall;
    logic [NUM_SRC-1:0] active;
    logic               take;
    logic [VEC_W-1:0]   take_src;

    irq_pin_sampler #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_smp (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_i),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    irq_flag_bank #(.PORT_W(PORT_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_level_i (lvl[EXT_PIN]),
        .ext_rise_i  (rise[EXT_PIN]),
        .ext_fall_i  (fall[EXT_PIN]),
        .pin_chg_i   (rise | fall),
        .hw_evt_i    ({cmp_evt_i, mem_rdy_i, tmr_ovf_i}),
        .reg_wr_i    (reg_wr_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .take_i      (take),
        .take_src_i  (take_src),
        .reti_i      (reti_i),
        .active_o    (active)
    );

    irq_arbiter u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (active),
        .vec_ack_i  (vec_ack_i),
        .reti_i     (reti_i),
        .retire_i   (retire_i),
        .vec_req_o  (vec_req_o),
        .vec_idx_o  (vec_idx_o),
        .take_o     (take),
        .take_src_o (take_src)
    );
endmodule

// File: tb/irq_ctrl_top_tb.sv
module irq_ctrl_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int EXT = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] pins = 6'h3F;
    logic       tmr = 1'b0, mem = 1'b0, cmp = 1'b0;
    logic       wr = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       vreq;
    logic [2:0] vidx;
    logic       ack = 1'b0, reti = 1'b0, retire = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_ctrl_top dut_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pins),
        .tmr_ovf_i(tmr), .mem_rdy_i(mem), .cmp_evt_i(cmp),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .vec_req_o(vreq), .vec_idx_o(vidx),
        .vec_ack_i(ack), .reti_i(reti), .retire_i(retire)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = 8'd0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        chk(rdata === exp, tag, rdata, exp);
    endtask

    task automatic req_chk(input bit exp_req, input logic [2:0] exp_idx, input string tag);
        chk(vreq === exp_req, {tag, " req"}, vreq, exp_req);
        if (exp_req) chk(vidx === exp_idx, {tag, " idx"}, vidx, exp_idx);
    endtask

    task automatic pulse_hw(input bit t, input bit m, input bit c);
        @(negedge clk);
        tmr = t; mem = m; cmp = c;
        @(negedge clk);
        tmr = 1'b0; mem = 1'b0; cmp = 1'b0;
    endtask

    task automatic strobe_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic strobe_reti();
        @(negedge clk); reti = 1'b1;
        @(negedge clk); reti = 1'b0;
    endtask

    task automatic strobe_retire();
        @(negedge clk); retire = 1'b1;
        @(negedge clk); retire = 1'b0;
    endtask

    task automatic serve();
        strobe_ack(); settle(); strobe_reti(); settle(); strobe_retire(); settle();
    endtask

    task automatic set_pin(input int p, input bit v);
        @(negedge clk);
        pins[p] = v;
    endtask

    // R1, R2: reset values
    task automatic t_reset();
        req_chk(1'b0, 3'd0, "R1 reset");
        rd_chk(2'd0, 8'h00, "R1 flags");
        rd_chk(2'd1, 8'h00, "R1 mask");
        rd_chk(2'd2, 8'h00, "R1 ctrl");
        rd_chk(2'd3, 8'h00, "R1 pcen");
        wr_reg(2'd3, 8'h2A);
        rd_chk(2'd3, 8'h2A, "R2 pcen readback");
        wr_reg(2'd3, 8'h00);
    endtask

    // R13, R4, R5, R6, R12, R3
    task automatic t_priority();
        wr_reg(2'd1, 8'h1F);
        wr_reg(2'd2, 8'h06);
        pulse_hw(1'b1, 1'b1, 1'b1);
        settle();
        rd_chk(2'd0, 8'h1C, "R13 hw flags");
        req_chk(1'b0, 3'd0, "R3 gie off");
        wr_reg(2'd2, 8'h07);
        settle();
        req_chk(1'b1, 3'd3, "R4 timer first");
        repeat (4) @(negedge clk);
        req_chk(1'b1, 3'd3, "R5 held");
        strobe_ack();
        settle();
        req_chk(1'b0, 3'd0, "R6 after ack");
        rd_chk(2'd0, 8'h18, "R6 flag cleared");
        rd_chk(2'd2, 8'h06, "R6 gie cleared");
        strobe_reti();
        settle();
        rd_chk(2'd2, 8'h07, "R6 gie set by return");
        req_chk(1'b0, 3'd0, "R12 holdoff");
        strobe_retire();
        settle();
        req_chk(1'b1, 3'd4, "R12 after retire / R4 mem");
        serve();
        req_chk(1'b1, 3'd5, "R4 comparator last");
        serve();
        req_chk(1'b0, 3'd0, "R4 all served");
        rd_chk(2'd0, 8'h00, "R6 flags empty");
        wr_reg(2'd1, 8'h00);
    endtask

    // R7, R3, R13
    task automatic t_gating();
        pulse_hw(1'b0, 1'b0, 1'b1);
        settle();
        req_chk(1'b0, 3'd0, "R3 mask off");
        rd_chk(2'd0, 8'h10, "R7 pending kept");
        wr_reg(2'd0, 8'h0F);
        rd_chk(2'd0, 8'h10, "R7 write zero no effect");
        wr_reg(2'd0, 8'h10);
        rd_chk(2'd0, 8'h00, "R7 write one clears");
        pulse_hw(1'b0, 1'b0, 1'b1);
        wr_reg(2'd1, 8'h10);
        settle();
        req_chk(1'b1, 3'd5, "R3 enabled later");
        serve();
        wr_reg(2'd1, 8'h00);
        wr_reg(2'd2, 8'h06);
        @(negedge clk);
        wr = 1'b1; addr = 2'd0; wdata = 8'h04; tmr = 1'b1;
        @(negedge clk);
        wr = 1'b0; wdata = 8'h00; tmr = 1'b0;
        rd_chk(2'd0, 8'h04, "R13 set beats clear");
        wr_reg(2'd0, 8'h1F);
    endtask

    // R8: edge modes on the external pin
    task automatic t_ext_edges();
        wr_reg(2'd2, 8'h04);
        set_pin(EXT, 1'b0); settle();
        rd_chk(2'd0, 8'h01, "R8 falling seen");
        wr_reg(2'd0, 8'h01);
        set_pin(EXT, 1'b1); settle();
        rd_chk(2'd0, 8'h00, "R8 rise ignored in fall mode");
        wr_reg(2'd2, 8'h06);
        set_pin(EXT, 1'b0); settle();
        rd_chk(2'd0, 8'h00, "R8 fall ignored in rise mode");
        set_pin(EXT, 1'b1); settle();
        rd_chk(2'd0, 8'h01, "R8 rising seen");
        wr_reg(2'd0, 8'h01);
        wr_reg(2'd2, 8'h02);
        set_pin(EXT, 1'b0); settle();
        rd_chk(2'd0, 8'h01, "R8 any: fall");
        wr_reg(2'd0, 8'h01);
        set_pin(EXT, 1'b1); settle();
        rd_chk(2'd0, 8'h01, "R8 any: rise");
        wr_reg(2'd0, 8'h01);
    endtask

    // R9: low-level mode
    task automatic t_level();
        wr_reg(2'd2, 8'h01);
        wr_reg(2'd1, 8'h01);
        settle();
        req_chk(1'b0, 3'd0, "R9 pin high idle");
        set_pin(EXT, 1'b0); settle();
        req_chk(1'b1, 3'd1, "R9 low requests");
        rd_chk(2'd0, 8'h00, "R9 flag reads zero");
        serve();
        req_chk(1'b1, 3'd1, "R9 still low re-requests");
        strobe_ack();
        set_pin(EXT, 1'b1); settle();
        strobe_reti(); strobe_retire(); settle();
        req_chk(1'b0, 3'd0, "R9 released");
        wr_reg(2'd1, 8'h00);
        wr_reg(2'd2, 8'h02);
        wr_reg(2'd0, 8'h1F);
    endtask

    // R10, R11: pin change
    task automatic t_pin_change();
        wr_reg(2'd3, 8'h08);
        set_pin(3, 1'b0); settle();
        rd_chk(2'd0, 8'h02, "R10 enabled pin change");
        wr_reg(2'd0, 8'h02);
        set_pin(4, 1'b0); settle();
        rd_chk(2'd0, 8'h00, "R10 disabled pin ignored");
        set_pin(4, 1'b1); set_pin(3, 1'b1); settle();
        wr_reg(2'd0, 8'h1F);
        wr_reg(2'd3, 8'h04);
        set_pin(EXT, 1'b0); settle();
        rd_chk(2'd0, 8'h03, "R10 one edge two flags");
        set_pin(EXT, 1'b1); settle();
        wr_reg(2'd0, 8'h1F);
        rd_chk(2'd0, 8'h00, "R10 cleared");
        wr_reg(2'd3, 8'h08);
        @(negedge clk); pins[3] = 1'b0;
        @(negedge clk);
        @(negedge clk); pins[3] = 1'b1;
        settle();
        rd_chk(2'd0, 8'h02, "R11 two-cycle pulse");
        wr_reg(2'd0, 8'h1F);
        wr_reg(2'd3, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 20000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_priority();
        t_gating();
        t_ext_edges();
        t_level();
        t_pin_change();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule